// File: doc/BRIEF.md
# Null-Terminated String Character Locator

This block walks a zero-terminated byte string held in memory and reports where a chosen character first appears. A caller supplies a base address and a target byte, then pulses a start input. The block reads the string one byte at a time through a request/valid memory port, starting at the base, and stops at the first byte that equals the target. If the target never appears, the scan stops on the zero byte that ends the string and reports that byte's offset instead.

A found flag tells the caller which of the two cases happened. The zero test is applied to every byte ahead of the target comparison, so a target of zero can never be reported as found. An optional length guard stops a runaway scan over memory that holds no terminator and raises an overrun flag.

Results appear together with a one-cycle done pulse. They stay on the outputs until the next scan finishes.

Top module: `strscan_locate`

## Requirements
- R1: After start, the first read is at the base address. Each later read is at base plus the current offset, with the offset beginning at zero and rising by one per read.
- R2: When a byte equals the target, the scan ends. index_o is that byte's offset, found_o=1 and overrun_o=0. If the target occurs more than once, the lowest offset is reported.
- R3: When the zero byte is reached with no earlier match, index_o is the zero byte's offset, found_o=0 and overrun_o=0. This includes an empty string, which gives index 0.
- R4: Each byte is tested for zero before it is compared with the target. A target of 0x00 therefore gives found_o=0 and the offset of the terminator.
- R5: done_o is high for exactly one cycle per scan. index_o, found_o and overrun_o change only in a cycle where done_o is high.
- R6: mem_req_o stays high, with mem_addr_o unchanged, until mem_valid_i is seen. Any number of wait cycles per byte is accepted.
- R7: With the guard enabled, if MAX_LEN bytes have been examined without a zero or a match, the scan ends with overrun_o=1, found_o=0 and index_o=MAX_LEN. A terminator at offset MAX_LEN-1 still completes normally.
- R8: A start pulse while a scan is in progress is ignored and does not change that scan's result.
- R9: A scan that ends on a match or a terminator makes exactly index_o+1 reads, and no request is outstanding when done_o is high.
- R10: After reset, done_o, mem_req_o, index_o, found_o and overrun_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (sampled only when idle) |
| base_i | input | ADDR_W | Address of the first string byte |
| target_i | input | 8 | Character to locate |
| done_o | output | 1 | One-cycle completion pulse |
| index_o | output | IDX_W | Offset of the match, the terminator, or MAX_LEN on overrun |
| found_o | output | 1 | Scan stopped on a match |
| overrun_o | output | 1 | Scan stopped by the length guard |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | ADDR_W | Byte read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data byte |

## Verification
A corrupted offset register shows up on the port within one memory transaction, as a read at the wrong mem_addr_o. It also shows up at done_o, as a wrong index_o. A wrong state, or a wrong order of the zero and match tests, shows up when the scan ends: a wrong found_o, an extra or missing read, or a done_o that is stuck or too long. The address of every read is logged and compared against base plus read number, so an offset error is caught at the first read it affects rather than only at completion.

// File: rtl/strscan_pkg.sv
package strscan_pkg;

    typedef logic [7:0] char_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CMP  = 2'd2
    } scan_state_e;

    localparam char_t NUL_CHAR = 8'h00;

endpackage

// File: rtl/strscan_classify.sv
module strscan_classify
    import strscan_pkg::*;
(
    input  char_t byte_i,
    input  char_t target_i,
    output logic  is_nul_o,
    output logic  is_hit_o
);
    // The zero test takes priority: a zero byte is never reported as a hit.
    always_comb begin
        is_nul_o = (byte_i == NUL_CHAR);
        is_hit_o = !is_nul_o && (byte_i == target_i);
    end
endmodule

// File: rtl/strscan_addr.sv
module strscan_addr #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        addr_o = base_i + ADDR_W'(offset_i);
    end
endmodule

// File: rtl/strscan_limit.sv
module strscan_limit #(
    parameter int IDX_W    = 16,
    parameter int MAX_LEN  = 4096,
    parameter bit LIMIT_EN = 1'b1
) (
    input  logic [IDX_W-1:0] next_off_i,
    output logic             limit_hit_o
);
    generate
        if (LIMIT_EN) begin : g_guard
            localparam logic [IDX_W-1:0] LIMIT_VAL = IDX_W'(MAX_LEN);
            assign limit_hit_o = (next_off_i == LIMIT_VAL);
        end else begin : g_noguard
            assign limit_hit_o = 1'b0 & (|next_off_i);
        end
    endgenerate
endmodule

// File: rtl/strscan_locate.sv
module strscan_locate
    import strscan_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 16,
    parameter int MAX_LEN  = 4096,
    parameter bit LIMIT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [7:0]        target_i,
    output logic              done_o,
    output logic [IDX_W-1:0]  index_o,
    output logic              found_o,
    output logic              overrun_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [7:0]        mem_data_i
);

    typedef struct packed {
        scan_state_e       state;
        logic [ADDR_W-1:0] base;
        char_t             target;
        logic [IDX_W-1:0]  offset;
        char_t             data;
        logic              req;
        logic              done;
        logic [IDX_W-1:0]  index;
        logic              found;
        logic              overrun;
    } regs_t;

    regs_t q, d;

    logic             is_nul;
    logic             is_hit;
    logic             limit_hit;
    logic [IDX_W-1:0] next_off;

    assign next_off = q.offset + IDX_W'(1);

    strscan_classify u_classify (
        .byte_i   (q.data),
        .target_i (q.target),
        .is_nul_o (is_nul),
        .is_hit_o (is_hit)
    );

    strscan_addr #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .base_i   (q.base),
        .offset_i (q.offset),
        .addr_o   (mem_addr_o)
    );

    strscan_limit #(
        .IDX_W    (IDX_W),
        .MAX_LEN  (MAX_LEN),
        .LIMIT_EN (LIMIT_EN)
    ) u_limit (
        .next_off_i  (next_off),
        .limit_hit_o (limit_hit)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.base   = base_i;
                    d.target = target_i;
                    d.offset = '0;
                    d.req    = 1'b1;
                    d.state  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_valid_i) begin
                    d.data  = mem_data_i;
                    d.req   = 1'b0;
                    d.state = ST_CMP;
                end
            end
            ST_CMP: begin
                if (is_nul || is_hit) begin
                    d.index   = q.offset;
                    d.found   = is_hit;
                    d.overrun = 1'b0;
                    d.done    = 1'b1;
                    d.state   = ST_IDLE;
                end else if (limit_hit) begin
                    d.index   = next_off;
                    d.found   = 1'b0;
                    d.overrun = 1'b1;
                    d.done    = 1'b1;
                    d.state   = ST_IDLE;
                end else begin
                    d.offset = next_off;
                    d.req    = 1'b1;
                    d.state  = ST_WAIT;
                end
            end
            default: begin
                d.req   = 1'b0;
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o    = q.done;
    assign index_o   = q.index;
    assign found_o   = q.found;
    assign overrun_o = q.overrun;
    assign mem_req_o = q.req;

endmodule

// File: rtl/strscan_locate_chk.sv
module strscan_locate_chk #(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 16,
    parameter int MAX_LEN  = 4096,
    parameter bit LIMIT_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [IDX_W-1:0]  index_o,
    input logic              found_o,
    input logic              overrun_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_valid_i
);

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(index_o) && $stable(found_o) && $stable(overrun_o)));

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(found_o && overrun_o));

    a_r7_overrun_index: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && overrun_o) |-> (LIMIT_EN && (index_o == IDX_W'(MAX_LEN))));

    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

endmodule

bind strscan_locate strscan_locate_chk #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .MAX_LEN  (MAX_LEN),
    .LIMIT_EN (LIMIT_EN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .index_o     (index_o),
    .found_o     (found_o),
    .overrun_o   (overrun_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i)
);

// File: tb/strscan_locate_bench.sv
`timescale 1ns/1ps
module strscan_locate_bench;

    localparam int AW   = 16;
    localparam int IW   = 16;
    localparam int LMAX = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [7:0]    target_i = '0;
    logic          done_o;
    logic [IW-1:0] index_o;
    logic          found_o;
    logic          overrun_o;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_valid = 1'b0;
    logic [7:0]    mem_rdata = '0;

    always #4 clk = ~clk;

    strscan_locate #(.ADDR_W(AW), .IDX_W(IW), .MAX_LEN(LMAX), .LIMIT_EN(1'b1)) u_strscan_locate (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .target_i(target_i),
        .done_o(done_o), .index_o(index_o), .found_o(found_o), .overrun_o(overrun_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid), .mem_data_i(mem_rdata)
    );

    // Byte memory with a variable-latency responder.
    logic [7:0]    mem [256];
    logic [AW-1:0] addr_log [512];
    int            rd_cnt = 0;
    int            wcnt = 0;
    int            lat = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            wcnt      <= 0;
        end else begin
            mem_valid <= 1'b0;
            if (mem_req_o && !mem_valid) begin
                if (wcnt >= lat + (rd_cnt % 2)) begin
                    mem_valid              <= 1'b1;
                    mem_rdata              <= mem[mem_addr_o[7:0]];
                    addr_log[rd_cnt % 512] <= mem_addr_o;
                    rd_cnt                 <= rd_cnt + 1;
                    wcnt                   <= 0;
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] base;
        logic [7:0]  tgt;
        logic [7:0]  lat;
        logic [15:0] idx;
        logic        found;
        logic        over;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 8'h6c, 8'd0, 16'd2,  1'b1, 1'b0},  // R2 'l' in "hello"
        '{16'h0000, 8'h68, 8'd2, 16'd0,  1'b1, 1'b0},  // R2 first byte
        '{16'h0000, 8'h7a, 8'd1, 16'd5,  1'b0, 1'b0},  // R3 miss
        '{16'h0000, 8'h00, 8'd0, 16'd5,  1'b0, 1'b0},  // R4 target zero
        '{16'h0010, 8'h61, 8'd3, 16'd0,  1'b0, 1'b0},  // R3 empty string
        '{16'h0020, 8'h71, 8'd0, 16'd12, 1'b0, 1'b1},  // R7 overrun
        '{16'h0020, 8'h78, 8'd1, 16'd0,  1'b1, 1'b0},  // R2
        '{16'h0040, 8'h62, 8'd2, 16'd1,  1'b1, 1'b0},  // R2 lowest of two
        '{16'h0060, 8'h71, 8'd0, 16'd11, 1'b0, 1'b0},  // R7 terminator at LMAX-1
        '{16'h0080, 8'h71, 8'd1, 16'd12, 1'b0, 1'b1},  // R7 terminator at LMAX
        '{16'h0040, 8'h63, 8'd5, 16'd2,  1'b1, 1'b0}   // R6 long waits
    };

    int r_idx, r_found, r_over, r_reads, r_done_w;
    bit r_addr_ok;

    task automatic run_scan(input logic [15:0] b, input logic [7:0] t, input int l, input bit poke);
        int start_rd;
        int cyc;
        lat = l;
        @(negedge clk);
        start_rd = rd_cnt;
        base_i   = b;
        target_i = t;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            base_i   = 16'h0000;
            target_i = 8'h68;
            start_i  = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (!done_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done_o == 1'b1, "R5", "done seen before timeout", cyc, 0);
        r_idx   = int'(index_o);
        r_found = int'(found_o);
        r_over  = int'(overrun_o);
        r_reads = rd_cnt - start_rd;
        r_addr_ok = 1'b1;
        for (int k = 0; k < r_reads; k++) begin
            if (addr_log[(start_rd + k) % 512] != b + 16'(k)) r_addr_ok = 1'b0;
        end
        chk(mem_req_o == 1'b0, "R9", "no request at done", int'(mem_req_o), 0);
        @(negedge clk);
        r_done_w = int'(done_o);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'h5a;
        mem[0] = 8'h68; mem[1] = 8'h65; mem[2] = 8'h6c; mem[3] = 8'h6c; mem[4] = 8'h6f; mem[5] = 8'h00;
        mem[16] = 8'h00;
        for (int a = 0; a < 20; a++) mem[32 + a] = 8'h78;
        mem[52] = 8'h00;
        mem[64] = 8'h61; mem[65] = 8'h62; mem[66] = 8'h63; mem[67] = 8'h61; mem[68] = 8'h62; mem[69] = 8'h00;
        for (int a = 0; a < 11; a++) mem[96 + a] = 8'h79;
        mem[107] = 8'h00;
        for (int a = 0; a < 12; a++) mem[128 + a] = 8'h79;
        mem[140] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(done_o == 1'b0,    "R10", "done after reset",    int'(done_o), 0);
        chk(mem_req_o == 1'b0, "R10", "req after reset",     int'(mem_req_o), 0);
        chk(index_o == '0,     "R10", "index after reset",   int'(index_o), 0);
        chk(found_o == 1'b0,   "R10", "found after reset",   int'(found_o), 0);
        chk(overrun_o == 1'b0, "R10", "overrun after reset", int'(overrun_o), 0);

        for (int v = 0; v < NV; v++) begin
            int er;
            run_scan(VEC[v].base, VEC[v].tgt, int'(VEC[v].lat), 1'b0);
            er = VEC[v].over ? int'(VEC[v].idx) : int'(VEC[v].idx) + 1;
            chk(r_idx == int'(VEC[v].idx),     "R2/R3", $sformatf("vec %0d index", v), r_idx, int'(VEC[v].idx));
            chk(r_found == int'(VEC[v].found), "R4", $sformatf("vec %0d found", v), r_found, int'(VEC[v].found));
            chk(r_over == int'(VEC[v].over),   "R7", $sformatf("vec %0d overrun", v), r_over, int'(VEC[v].over));
            chk(r_reads == er,                 "R9", $sformatf("vec %0d reads", v), r_reads, er);
            chk(r_addr_ok,                     "R1", $sformatf("vec %0d read addresses", v), int'(r_addr_ok), 1);
            chk(r_done_w == 0,                 "R5", $sformatf("vec %0d done one cycle", v), r_done_w, 0);
        end

        // R5: result held while idle.
        repeat (5) @(negedge clk);
        chk(index_o == 16'd2 && found_o == 1'b1, "R5", "result held idle", int'(index_o), 2);

        // R8: start during a scan is ignored.
        run_scan(16'h0020, 8'h71, 2, 1'b1);
        chk(r_idx == 12,  "R8", "busy start index",   r_idx, 12);
        chk(r_over == 1,  "R8", "busy start overrun", r_over, 1);
        chk(r_reads == 12, "R8", "busy start reads",  r_reads, 12);
        chk(r_addr_ok,    "R8", "busy start addresses", int'(r_addr_ok), 1);
        @(negedge clk);
        chk(done_o == 1'b0 && mem_req_o == 1'b0, "R8", "no second scan", int'(mem_req_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule